// File: doc/BRIEF.md
# Packed Calendar Clock with BCD Year

This block is a time-of-day and date counter that keeps the calendar directly in field form. Seconds, minutes, hours, weekday, day of month and month share one 32-bit word. The year sits in a separate 16-bit word as two BCD bytes, century and year-within-century. The block counts pulses of a 32768 Hz reference, which reaches the clock domain as a one-cycle enable. When the run control is high, a prescaler turns these pulses into one step per second. Each step carries through the fields with correct month lengths, the leap-year rule, a rotating weekday and a BCD year increment.

Software sets the calendar in two writes. It first writes the year load, which is only staged. The following time load then commits the time word and the staged year in the same clock cycle, and it also restarts the prescaler. A pair of match words, one for time and one for year, is compared against the running calendar. Whenever the calendar is updated to a value equal to both match words, the block raises a one-cycle alarm event. The mask, the sticky status and the clear logic sit outside this block.

Top module: `cal_clock_core`

## Requirements
- R1: Time word fields are: seconds [5:0], minutes [11:6], hours [16:12], weekday [19:17] (1=Sunday to 7=Saturday), day of month [24:20], month [28:25] (1=January), with [31:29] zero. The year word is BCD, with century in [15:8] and year in [7:0]. After reset the time word is 0x021E0000 (Saturday 1 January, 00:00:00), the year word is 0x2000 and alarm_pulse is low.
- R2: With run_en high, the calendar steps by one second on every 2**PRE_W-th ref_tick pulse (32768 at the default PRE_W=15). Nothing steps without ref_tick. A time load restarts the prescaler from zero.
- R3: While run_en is low, neither the calendar nor the prescaler count moves.
- R4: Seconds wrap from 59 to 0 with a carry into minutes, minutes wrap from 59 to 0 with a carry into hours, and hours wrap from 23 to 0 with a carry into the day.
- R5: The day of month wraps to 1 after day 30 in April, June, September and November, and after day 31 in the other months except February. The month then advances.
- R6: February has 29 days when the year is divisible by 4 and either the BCD year byte is nonzero or the century is divisible by 4. Otherwise it has 28 days.
- R7: The weekday advances on each day change and wraps from 7 to 1.
- R8: After 31 December 23:59:59 the calendar becomes 1 January 00:00:00. The year increments in BCD, carries from the year byte into the century byte, and 9999 wraps to 0000.
- R9: A year load changes only the staged year and leaves cal_year unchanged. A time load sets cal_time to the loaded word and cal_year to the staged year in the same cycle. The staged year persists for later time loads.
- R10: alarm_pulse is high for exactly one cycle: the cycle after a second step or a time load that leaves cal_time and cal_year equal to the time match word and the year match word. It stays low if either word differs.
- R11: The time match word and the year match word are each written by their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per 32768 Hz reference period |
| run_en | input | 1 | Calendar counting enable |
| year_ld_we | input | 1 | Stage year_ld_data as the next year |
| year_ld_data | input | 16 | BCD year value to stage |
| time_ld_we | input | 1 | Load time word and commit staged year |
| time_ld_data | input | 32 | Time word to load |
| match_time_we | input | 1 | Write the time match word |
| match_time_data | input | 32 | Time match value |
| match_year_we | input | 1 | Write the year match word |
| match_year_data | input | 16 | BCD year match value |
| cal_time | output | 32 | Current packed time word |
| cal_year | output | 16 | Current BCD year word |
| alarm_pulse | output | 1 | One-cycle match event |

## Verification
A load takes effect at the clock edge that samples its strobe and is visible half a cycle later. A second step lands on the 2**PRE_W-th edge with both run_en and ref_tick high. The alarm appears in the cycle right after the stepping or loading edge and is gone one cycle later. The bench runs with PRE_W=2, so a second takes four enabled edges. It drives every input on the falling edge and samples on the falling edge after the edge named above. It checks partial counts one edge short of the step as well as on the step itself. The calendar sweeps compare every step against a bench model that counts in binary and converts to BCD and packed fields.

// File: rtl/cal_pkg.sv
// Shared layout, reset constants and BCD helper for the packed calendar clock.
package cal_pkg;

    localparam int YEAR_DIGITS = 4;
    localparam int YEAR_W      = 4 * YEAR_DIGITS;
    localparam int TIME_W      = 32;

    // Packed time word: field order sets the bit positions seen by software.
    typedef struct packed {
        logic [2:0] pad;    // [31:29] always zero on a valid word
        logic [3:0] mon;    // [28:25] 1 = January
        logic [4:0] mday;   // [24:20] 1..31
        logic [2:0] wday;   // [19:17] 1 = Sunday .. 7 = Saturday
        logic [4:0] hour;   // [16:12] 0..23
        logic [5:0] mins;   // [11:6]  0..59
        logic [5:0] secs;   // [5:0]   0..59
    } cal_word_t;

    localparam cal_word_t RESET_WORD = '{pad: 3'd0, mon: 4'd1, mday: 5'd1, wday: 3'd7,
                                         hour: 5'd0, mins: 6'd0, secs: 6'd0};
    localparam logic [YEAR_W-1:0] RESET_YEAR = 16'h2000;

    // Two BCD digits to binary 0..99.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Divides the reference pulse stream down to one seconds tick.
// Assumes count_en is already qualified by the run control; clear wins over counting.
module cal_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic sec_tick
);

    logic [PRE_W-1:0] cnt_q;

    // Free-running modulo-2**PRE_W count of enabled reference pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear)    cnt_q <= '0;
        else if (count_en) cnt_q <= cnt_q + 1'b1;
    end

    // Tick on the pulse that wraps the count.
    assign sec_tick = count_en && (&cnt_q) && !clear;

endmodule

// File: rtl/cal_month_len.sv
// Returns the number of days in a month for a given BCD year word.
// Assumes month codes 1..12; other codes are treated as 31-day months.
module cal_month_len
    import cal_pkg::*;
(
    input  logic [3:0]        mon,
    input  logic [YEAR_W-1:0] year_bcd,
    output logic [4:0]        days
);

    logic [6:0] yy_bin;
    logic [6:0] cc_bin;
    logic       leap;

    assign yy_bin = bcd_to_bin(year_bcd[7:0]);
    assign cc_bin = bcd_to_bin(year_bcd[15:8]);

    // Divisible by 4, except a century year must have a century divisible by 4.
    assign leap = (yy_bin[1:0] == 2'b00) && ((yy_bin != 7'd0) || (cc_bin[1:0] == 2'b00));

    // Month length lookup.
    always_comb begin
        unique case (mon)
            4'd2:                      days = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   days = 5'd30;
            default:                   days = 5'd31;
        endcase
    end

endmodule

// File: rtl/cal_year_inc.sv
// Adds one to a multi-digit BCD year word; the top digit wraps from 9 to 0.
module cal_year_inc
    import cal_pkg::*;
(
    input  logic [YEAR_W-1:0] year_in,
    output logic [YEAR_W-1:0] year_out
);

    logic       carry;
    logic [3:0] dig;

    // Ripple a decimal carry from the least significant digit upward.
    always_comb begin
        carry    = 1'b1;
        dig      = 4'd0;
        year_out = year_in;
        for (int i = 0; i < YEAR_DIGITS; i++) begin
            dig = year_in[4*i +: 4];
            if (carry) begin
                if (dig >= 4'd9) begin
                    year_out[4*i +: 4] = 4'd0;
                end else begin
                    year_out[4*i +: 4] = dig + 4'd1;
                    carry = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/cal_date_step.sv
// Computes the calendar one second later: field carries, month length, weekday, year.
// Assumes in-range fields; out-of-range values are folded to the wrap value.
module cal_date_step
    import cal_pkg::*;
(
    input  cal_word_t         cur,
    input  logic [YEAR_W-1:0] year_cur,
    output cal_word_t         nxt,
    output logic [YEAR_W-1:0] year_nxt
);

    logic [4:0]        mlen;
    logic [YEAR_W-1:0] year_plus;

    cal_month_len u_mlen (
        .mon      (cur.mon),
        .year_bcd (year_cur),
        .days     (mlen)
    );

    cal_year_inc u_yinc (
        .year_in  (year_cur),
        .year_out (year_plus)
    );

    // Carry chain from seconds up to the year.
    always_comb begin
        nxt      = cur;
        year_nxt = year_cur;
        if (cur.secs >= 6'd59) begin
            nxt.secs = 6'd0;
            if (cur.mins >= 6'd59) begin
                nxt.mins = 6'd0;
                if (cur.hour >= 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday >= mlen) begin
                        nxt.mday = 5'd1;
                        if (cur.mon >= 4'd12) begin
                            nxt.mon  = 4'd1;
                            year_nxt = year_plus;
                        end else begin
                            nxt.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 5'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.mins = cur.mins + 6'd1;
            end
        end else begin
            nxt.secs = cur.secs + 6'd1;
        end
    end

endmodule

// File: rtl/cal_clock_core.sv
// Packed calendar clock: prescaled seconds, staged year load, time+year match event.
// Assumes ref_tick is a clean one-cycle pulse already in the clk domain and that
// the alarm mask, sticky status and clear are implemented by the surrounding logic.
module cal_clock_core
    import cal_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        run_en,
    input  logic        year_ld_we,
    input  logic [15:0] year_ld_data,
    input  logic        time_ld_we,
    input  logic [31:0] time_ld_data,
    input  logic        match_time_we,
    input  logic [31:0] match_time_data,
    input  logic        match_year_we,
    input  logic [15:0] match_year_data,
    output logic [31:0] cal_time,
    output logic [15:0] cal_year,
    output logic        alarm_pulse
);

    cal_word_t         cal_q;
    cal_word_t         cal_nxt;
    logic [YEAR_W-1:0] year_q;
    logic [YEAR_W-1:0] year_nxt;
    logic [YEAR_W-1:0] year_stage_q;
    logic [TIME_W-1:0] match_time_q;
    logic [YEAR_W-1:0] match_year_q;
    logic              upd_q;
    logic              sec_tick;

    cal_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (time_ld_we),
        .count_en (run_en && ref_tick),
        .sec_tick (sec_tick)
    );

    cal_date_step u_step (
        .cur      (cal_q),
        .year_cur (year_q),
        .nxt      (cal_nxt),
        .year_nxt (year_nxt)
    );

    // Running calendar: a time load commits the staged year, else step on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q  <= RESET_WORD;
            year_q <= RESET_YEAR;
        end else if (time_ld_we) begin
            cal_q  <= cal_word_t'(time_ld_data);
            year_q <= year_stage_q;
        end else if (sec_tick) begin
            cal_q  <= cal_nxt;
            year_q <= year_nxt;
        end
    end

    // Year staging register, written ahead of the time load.
    always_ff @(posedge clk) begin
        if (!rst_n)          year_stage_q <= RESET_YEAR;
        else if (year_ld_we) year_stage_q <= year_ld_data;
    end

    // Match words for the alarm comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_time_q <= '0;
            match_year_q <= '0;
        end else begin
            if (match_time_we) match_time_q <= match_time_data;
            if (match_year_we) match_year_q <= match_year_data;
        end
    end

    // Marks the cycle right after the calendar was updated.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= time_ld_we || sec_tick;
    end

    assign cal_time    = cal_q;
    assign cal_year    = year_q;
    assign alarm_pulse = upd_q && (cal_time == match_time_q) && (year_q == match_year_q);

endmodule

// File: rtl/cal_clock_chk.sv
// Property checker for cal_clock_core, attached with bind below.
module cal_clock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ref_tick,
    input logic        run_en,
    input logic        time_ld_we,
    input logic [31:0] time_ld_data,
    input logic [31:0] cal_time,
    input logic [15:0] cal_year,
    input logic        alarm_pulse,
    input logic        sec_tick,
    input logic [15:0] year_stage_q
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cal_time == 32'h021E_0000 && cal_year == 16'h2000 && !alarm_pulse));

    a_r2_tick_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (run_en && ref_tick && !time_ld_we));

    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !time_ld_we) |=> ($stable(cal_time) && $stable(cal_year)));

    a_r4_sec_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && cal_time[5:0] < 6'd59) |=>
            (cal_time[5:0] == $past(cal_time[5:0]) + 6'd1 &&
             cal_time[31:6] == $past(cal_time[31:6]) && $stable(cal_year)));

    a_r7_weekday_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && cal_time[16:0] == {5'd23, 6'd59, 6'd59} && cal_time[19:17] != 3'd0) |=>
            (cal_time[19:17] == (($past(cal_time[19:17]) == 3'd7) ? 3'd1
                                  : $past(cal_time[19:17]) + 3'd1)));

    a_r9_load_commit: assert property (@(posedge clk) disable iff (!rst_n)
        time_ld_we |=> (cal_time == $past(time_ld_data) && cal_year == $past(year_stage_q)));

    a_r10_alarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> $past(sec_tick || time_ld_we));

    a_r10_alarm_single: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_pulse && !sec_tick && !time_ld_we) |=> !alarm_pulse);

endmodule

bind cal_clock_core cal_clock_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .run_en       (run_en),
    .time_ld_we   (time_ld_we),
    .time_ld_data (time_ld_data),
    .cal_time     (cal_time),
    .cal_year     (cal_year),
    .alarm_pulse  (alarm_pulse),
    .sec_tick     (sec_tick),
    .year_stage_q (year_stage_q)
);

// File: tb/cal_clock_core_tb.sv
`timescale 1ns/1ps
module cal_clock_core_tb;

    localparam int PRE_W = 2;
    localparam int SPS   = 1 << PRE_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        run_en = 1'b0;
    logic        year_ld_we = 1'b0;
    logic [15:0] year_ld_data = '0;
    logic        time_ld_we = 1'b0;
    logic [31:0] time_ld_data = '0;
    logic        match_time_we = 1'b0;
    logic [31:0] match_time_data = '0;
    logic        match_year_we = 1'b0;
    logic [15:0] match_year_data = '0;
    logic [31:0] cal_time;
    logic [15:0] cal_year;
    logic        alarm_pulse;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    cal_clock_core #(.PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run_en(run_en),
        .year_ld_we(year_ld_we), .year_ld_data(year_ld_data),
        .time_ld_we(time_ld_we), .time_ld_data(time_ld_data),
        .match_time_we(match_time_we), .match_time_data(match_time_data),
        .match_year_we(match_year_we), .match_year_data(match_year_data),
        .cal_time(cal_time), .cal_year(cal_year), .alarm_pulse(alarm_pulse)
    );

    always #2.5 clk = ~clk;

    // ---- reference model ----
    function automatic logic [31:0] pack_t(int mo, int md, int wd, int hr, int mi, int se);
        return {3'b000, 4'(mo), 5'(md), 3'(wd), 5'(hr), 6'(mi), 6'(se)};
    endfunction

    function automatic int year_bin(logic [15:0] y);
        return int'(y[15:12]) * 1000 + int'(y[11:8]) * 100 + int'(y[7:4]) * 10 + int'(y[3:0]);
    endfunction

    function automatic logic [15:0] year_bcd(int v);
        return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(int mo, int yr);
        bit leap;
        leap = ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
        case (mo)
            2:             return leap ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    function automatic logic [47:0] model_next(logic [31:0] t, logic [15:0] y);
        int se, mi, hr, wd, md, mo, yr;
        se = int'(t[5:0]);   mi = int'(t[11:6]);  hr = int'(t[16:12]);
        wd = int'(t[19:17]); md = int'(t[24:20]); mo = int'(t[28:25]);
        yr = year_bin(y);
        se++;
        if (se == 60) begin
            se = 0; mi++;
            if (mi == 60) begin
                mi = 0; hr++;
                if (hr == 24) begin
                    hr = 0;
                    wd = (wd % 7) + 1;
                    md++;
                    if (md > days_in(mo, yr)) begin
                        md = 1; mo++;
                        if (mo == 13) begin
                            mo = 1;
                            yr = (yr + 1) % 10000;
                        end
                    end
                end
            end
        end
        return {pack_t(mo, md, wd, hr, mi, se), year_bcd(yr)};
    endfunction

    // ---- helpers ----
    task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(logic [31:0] t, logic [15:0] y);
        @(negedge clk);
        year_ld_we = 1'b1; year_ld_data = y;
        @(negedge clk);
        year_ld_we = 1'b0;
        time_ld_we = 1'b1; time_ld_data = t;
        @(negedge clk);
        time_ld_we = 1'b0;
    endtask

    task automatic run_edges(int n);
        @(negedge clk);
        run_en = 1'b1; ref_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run_en = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic step_sec();
        run_edges(SPS);
    endtask

    task automatic set_match(logic [31:0] t, logic [15:0] y);
        @(negedge clk);
        match_time_we = 1'b1; match_time_data = t;
        match_year_we = 1'b1; match_year_data = y;
        @(negedge clk);
        match_time_we = 1'b0; match_year_we = 1'b0;
    endtask

    // ---- watchdog ----
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        logic [47:0] exp;
        logic [31:0] t0;
        int years [6] = '{2023, 2024, 2000, 2100, 2096, 1900};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 reset calendar", {cal_time, cal_year}, {32'h021E_0000, 16'h2000});
        check("R1 reset alarm", {47'd0, alarm_pulse}, 48'd0);

        // R3: run_en low holds everything even with reference pulses
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (20) @(negedge clk);
        ref_tick = 1'b0;
        check("R3 hold while disabled", {cal_time, cal_year}, {32'h021E_0000, 16'h2000});

        // R2: no ref_tick, no step
        @(negedge clk);
        run_en = 1'b1;
        repeat (20) @(negedge clk);
        run_en = 1'b0;
        check("R2 no step without ref", {cal_time, cal_year}, {32'h021E_0000, 16'h2000});

        // R2/R3: partial count survives a pause
        t0 = pack_t(3, 10, 2, 8, 30, 0);
        load(t0, 16'h2024);
        check("R9 load commit", {cal_time, cal_year}, {t0, 16'h2024});
        run_edges(2);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (6) @(negedge clk);
        ref_tick = 1'b0;
        run_edges(1);
        check("R3 prescaler paused", {cal_time, cal_year}, {t0, 16'h2024});
        run_edges(1);
        check("R2 step after full count", {cal_time, cal_year}, {pack_t(3, 10, 2, 8, 30, 1), 16'h2024});

        // R2: time load restarts the prescaler
        run_edges(2);
        load(t0, 16'h2024);
        run_edges(SPS - 1);
        check("R2 restart one short", {cal_time, cal_year}, {t0, 16'h2024});
        run_edges(1);
        check("R2 restart step", {cal_time, cal_year}, {pack_t(3, 10, 2, 8, 30, 1), 16'h2024});

        // R4/R7/R8: run across minute, hour, day, month, year and century
        t0 = pack_t(12, 31, 6, 23, 58, 50);
        load(t0, 16'h1999);
        exp = {t0, 16'h1999};
        for (int i = 0; i < 80; i++) begin
            exp = model_next(exp[47:16], exp[15:0]);
            step_sec();
            check("R4 carry chain run", {cal_time, cal_year}, exp);
        end
        check("R8 century carry", {cal_time, cal_year},
              {pack_t(1, 1, 7, 0, 0, 10), 16'h2000});

        // R5/R6: every month end in several years
        foreach (years[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int d = 0; d < 2; d++) begin
                    int md;
                    md = days_in(mo, years[k]) - 1 + d;
                    t0 = pack_t(mo, md, 3, 23, 59, 59);
                    load(t0, year_bcd(years[k]));
                    exp = model_next(t0, year_bcd(years[k]));
                    step_sec();
                    if (mo == 2) check("R6 february length", {cal_time, cal_year}, exp);
                    else         check("R5 month length", {cal_time, cal_year}, exp);
                end
            end
        end

        // R7: every weekday code wraps correctly
        for (int wd = 1; wd <= 7; wd++) begin
            t0 = pack_t(5, 14, wd, 23, 59, 59);
            load(t0, 16'h2031);
            step_sec();
            check("R7 weekday rotate", {cal_time, cal_year},
                  {pack_t(5, 15, (wd % 7) + 1, 0, 0, 0), 16'h2031});
        end

        // R8: BCD year increments, including digit and century carries
        begin
            logic [15:0] yin [5]  = '{16'h2009, 16'h2019, 16'h2099, 16'h9999, 16'h1989};
            logic [15:0] yout [5] = '{16'h2010, 16'h2020, 16'h2100, 16'h0000, 16'h1990};
            for (int i = 0; i < 5; i++) begin
                load(pack_t(12, 31, 1, 23, 59, 59), yin[i]);
                step_sec();
                check("R8 year increment", {cal_time, cal_year},
                      {pack_t(1, 1, 2, 0, 0, 0), yout[i]});
            end
        end

        // R9: year load alone is only staged; it persists for later time loads
        t0 = pack_t(7, 4, 5, 12, 0, 0);
        load(t0, 16'h2030);
        @(negedge clk);
        year_ld_we = 1'b1; year_ld_data = 16'h2155;
        @(negedge clk);
        year_ld_we = 1'b0;
        @(negedge clk);
        check("R9 year staged only", {cal_time, cal_year}, {t0, 16'h2030});
        @(negedge clk);
        time_ld_we = 1'b1; time_ld_data = pack_t(8, 1, 1, 1, 1, 1);
        @(negedge clk);
        time_ld_we = 1'b0;
        check("R9 staged year committed", {cal_time, cal_year}, {pack_t(8, 1, 1, 1, 1, 1), 16'h2155});
        @(negedge clk);
        time_ld_we = 1'b1; time_ld_data = pack_t(9, 2, 2, 2, 2, 2);
        @(negedge clk);
        time_ld_we = 1'b0;
        check("R9 stage persists", {cal_time, cal_year}, {pack_t(9, 2, 2, 2, 2, 2), 16'h2155});

        // R10/R11: alarm on a matching step, single cycle, and year must match too
        set_match(pack_t(2, 29, 5, 6, 30, 0), 16'h2024);
        load(pack_t(2, 29, 5, 6, 29, 59), 16'h2024);
        check("R10 no alarm before match", {47'd0, alarm_pulse}, 48'd0);
        step_sec();
        check("R11 alarm on matching step", {47'd0, alarm_pulse}, 48'd1);
        @(negedge clk);
        check("R10 alarm single cycle", {47'd0, alarm_pulse}, 48'd0);
        load(pack_t(2, 29, 5, 6, 29, 59), 16'h2028);
        step_sec();
        check("R10 year mismatch no alarm", {47'd0, alarm_pulse}, 48'd0);
        load(pack_t(2, 29, 5, 6, 30, 0), 16'h2024);
        check("R10 alarm on matching load", {47'd0, alarm_pulse}, 48'd1);
        set_match(pack_t(2, 29, 5, 6, 30, 1), 16'h2024);
        step_sec();
        check("R11 new match word used", {47'd0, alarm_pulse}, 48'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule